// File: doc/BRIEF.md
# LCD Pixel Word Unpacker

This block sits between a pixel FIFO that delivers 32-bit memory words and the data pins of an LCD panel. Each accepted word is broken into output beats, one pixel per beat. The one exception is a 16-bit pixel on an 8-bit bus, which is sent as two byte beats. Static configuration inputs choose the layout of the words and the panel bus:

- a 2-bit pixel word length code;
- a 4-bit byte-valid mask;
- a 2-bit panel bus width code;
- a flag that narrows 24-bit colour to 18 bits.

In 16-bit mode each word carries two RGB565 pixels, and the lower halfword goes out first. In 24-bit mode each word carries one pixel in its low three bytes, and the top byte is never used. When the narrowing flag is set, each 8-bit component loses its two most significant bits, which gives an 18-bit pixel for 16- or 18-bit panels. A setting combination that the block does not support raises an error flag. While that flag is high the block neither accepts words nor drives beats.

Both sides use valid/ready handshakes:

- **Input side.** A word is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the holding register is empty. It is also high during the last beat of the current word when `out_ready` is high, so a full-rate stream has no gap between words.
- **Output side.** Once `out_valid` is high, it and `out_data` stay unchanged until `out_ready` is sampled high.

The configuration inputs must stay constant while a word is held.

Top module: `lcd_pixel_unpacker`

## Requirements
- R1: Word length code 0 with mask 0xF and bus code 1, 2 or 3 produces two beats per word. `out_data[15:0]` carries `word[15:0]` first and then `word[31:16]`, and `out_data[23:16]` is zero.
- R2: Word length code 0 with mask 0xF and bus code 0 produces four beats per word, in the order `word[7:0]`, `word[15:8]`, `word[23:16]`, `word[31:24]`. Each beat is in `out_data[7:0]`, and `out_data[23:8]` is zero.
- R3: Word length code 3 with mask 0x7 and the narrowing flag clear produces one beat with `out_data = word[23:0]`. `word[31:24]` has no effect.
- R4: Word length code 3 with mask 0x7 and the narrowing flag set produces one beat with `out_data[17:0] = {word[21:16], word[13:8], word[5:0]}`, and `out_data[23:18]` is zero.
- R5: In word length code 0 the narrowing flag has no effect on the output beats.
- R6: `cfg_error` is high exactly for the following settings, and while it is high `in_ready` and `out_valid` are both low:
  - word length code 1 or 2;
  - code 0 with a mask other than 0xF;
  - code 3 with a mask other than 0x7;
  - code 3 on bus code 0;
  - code 3 on bus code 1 or 2 with the narrowing flag clear.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay stable. `in_ready` stays low while a held word still has beats left to send.
- R8: With `out_ready` held high, a word offered during the last beat of the previous word is accepted on that same edge. Its first beat appears on the next cycle, with no idle cycle between the two words.
- R9: After reset the holding register is empty, so `out_valid` is low and `in_ready` is high for a valid configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word_len | input | 2 | Pixel word length code (0 = 16-bit, 3 = 24-bit) |
| cfg_byte_mask | input | 4 | Byte-valid mask of each input word |
| cfg_bus_width | input | 2 | Panel bus code (0 = 8, 1 = 16, 2 = 18, 3 = 24 bits) |
| cfg_narrow | input | 1 | Keep only the low six bits of each 8-bit component |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| in_data | input | 32 | Input pixel word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Panel side takes the beat |
| out_data | output | 24 | Output beat, unused upper bits zero |
| cfg_error | output | 1 | Unsupported configuration |

## Verification
The assertions take the configuration inputs as constant from the moment a word is accepted until its last beat leaves. The format checks on `out_data` and the rule that an accepted word shows up on the next cycle both depend on that assumption. The bench changes the configuration only while the holding register is empty: it drains every word before moving to the next table row. Back-pressure is applied by lowering `out_ready`, never by changing settings in mid-word.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  localparam logic [1:0] WLEN_16 = 2'd0;
  localparam logic [1:0] WLEN_24 = 2'd3;
  localparam logic [1:0] BUS_8   = 2'd0;
  localparam logic [1:0] BUS_24  = 2'd3;
  localparam logic [3:0] MASK_PAIR   = 4'hF;
  localparam logic [3:0] MASK_SINGLE = 4'h7;
  localparam int COMP_W   = 8;
  localparam int NARROW_W = 6;
  localparam int NCOMP    = 3;
endpackage

// File: rtl/unpack_cfg_check.sv
module unpack_cfg_check
  import unpack_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [1:0]        word_len,
  input  logic [3:0]        byte_mask,
  input  logic [1:0]        bus_width,
  input  logic              narrow,
  output logic              bad,
  output logic [BEAT_W-1:0] last_beat
);
  always_comb begin
    bad       = 1'b0;
    last_beat = '0;
    unique case (word_len)
      WLEN_16: begin
        bad       = (byte_mask != MASK_PAIR);
        last_beat = (bus_width == BUS_8) ? BEAT_W'(3) : BEAT_W'(1);
      end
      WLEN_24: begin
        bad = (byte_mask != MASK_SINGLE) || (bus_width == BUS_8) ||
              ((bus_width != BUS_24) && !narrow);
        last_beat = '0;
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/unpack_beat_mux.sv
module unpack_beat_mux
  import unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 24,
  parameter int BEAT_W = 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic [BEAT_W-1:0] beat,
  input  logic [1:0]        word_len,
  input  logic [1:0]        bus_width,
  input  logic              narrow,
  output logic [BUS_W-1:0]  pix
);
  localparam int HALF_W = WORD_W / 2;
  localparam int NARROW_PIX_W = NCOMP * NARROW_W;

  logic [NARROW_PIX_W-1:0] narrow_pix;

  genvar c;
  generate
    for (c = 0; c < NCOMP; c++) begin : g_comp
      assign narrow_pix[c*NARROW_W +: NARROW_W] = word[c*COMP_W +: NARROW_W];
    end
  endgenerate

  logic [HALF_W-1:0] half;

  always_comb begin
    pix  = '0;
    half = '0;
    if (word_len == WLEN_16) begin
      if (bus_width == BUS_8) begin
        half = beat[1] ? word[HALF_W +: HALF_W] : word[0 +: HALF_W];
        pix[COMP_W-1:0] = beat[0] ? half[COMP_W +: COMP_W] : half[0 +: COMP_W];
      end else begin
        half = beat[0] ? word[HALF_W +: HALF_W] : word[0 +: HALF_W];
        pix[HALF_W-1:0] = half;
      end
    end else if (narrow) begin
      pix[NARROW_PIX_W-1:0] = narrow_pix;
    end else begin
      pix[NCOMP*COMP_W-1:0] = word[NCOMP*COMP_W-1:0];
    end
  end
endmodule

// File: rtl/lcd_pixel_unpacker.sv
module lcd_pixel_unpacker #(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_word_len,
  input  logic [3:0]        cfg_byte_mask,
  input  logic [1:0]        cfg_bus_width,
  input  logic              cfg_narrow,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BUS_W-1:0]  out_data,
  output logic              cfg_error
);
  localparam int BEATS_MAX = WORD_W / 8;
  localparam int BEAT_W    = $clog2(BEATS_MAX);

  logic [WORD_W-1:0] word_q;
  logic              full_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] last_beat;
  logic              bad;

  unpack_cfg_check #(.BEAT_W(BEAT_W)) u_cfg (
    .word_len (cfg_word_len),
    .byte_mask(cfg_byte_mask),
    .bus_width(cfg_bus_width),
    .narrow   (cfg_narrow),
    .bad      (bad),
    .last_beat(last_beat)
  );

  unpack_beat_mux #(.WORD_W(WORD_W), .BUS_W(BUS_W), .BEAT_W(BEAT_W)) u_mux (
    .word     (word_q),
    .beat     (beat_q),
    .word_len (cfg_word_len),
    .bus_width(cfg_bus_width),
    .narrow   (cfg_narrow),
    .pix      (out_data)
  );

  logic at_last, in_fire, out_fire;

  assign cfg_error = bad;
  assign at_last   = (beat_q == last_beat);
  assign out_valid = full_q && !bad;
  assign out_fire  = out_valid && out_ready;
  assign in_ready  = !bad && (!full_q || (out_ready && at_last));
  assign in_fire   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      full_q <= 1'b0;
      beat_q <= '0;
    end else begin
      if (out_fire) begin
        if (at_last) begin
          full_q <= 1'b0;
          beat_q <= '0;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
      if (in_fire) begin
        word_q <= in_data;
        full_q <= 1'b1;
        beat_q <= '0;
      end
    end
  end
endmodule

// File: rtl/unpacker_checker.sv
module unpacker_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_word_len,
  input logic [1:0]  cfg_bus_width,
  input logic        cfg_narrow,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_data,
  input logic        cfg_error
);
  assert_wide16_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_word_len == 2'd0 && cfg_bus_width != 2'd0 |-> out_data[23:16] == 8'h0);

  assert_byte16_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_word_len == 2'd0 && cfg_bus_width == 2'd0 |-> out_data[23:8] == 16'h0);

  assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_word_len == 2'd3 && cfg_narrow |-> out_data[23:18] == 6'h0);

  assert_error_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !out_valid && !in_ready);

  assert_hold_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_accept_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_reset_empty_R9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind lcd_pixel_unpacker unpacker_checker u_chk (.*);

// File: tb/test_lcd_pixel_unpacker.sv
module test_lcd_pixel_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_word_len = 2'd0;
  logic [3:0]  cfg_byte_mask = 4'hF;
  logic [1:0]  cfg_bus_width = 2'd1;
  logic        cfg_narrow = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_data;
  logic        cfg_error;

  always #10 clk = ~clk;

  lcd_pixel_unpacker i_lcd_pixel_unpacker (.*);

  typedef struct packed {
    logic [1:0]  wl;
    logic [3:0]  mask;
    logic [1:0]  bus;
    logic        nar;
    logic        err;
    logic [2:0]  nb;
    logic [31:0] data;
    logic [23:0] b0, b1, b2, b3;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R1: 16-bit on 16-bit bus, low half first
    '{2'd0, 4'hF, 2'd1, 1'b0, 1'b0, 3'd2, 32'hA5C31E7F, 24'h001E7F, 24'h00A5C3, 24'h0, 24'h0},
    // R2: 16-bit on 8-bit bus, four bytes low first
    '{2'd0, 4'hF, 2'd0, 1'b0, 1'b0, 3'd4, 32'hA5C31E7F, 24'h00007F, 24'h00001E, 24'h0000C3, 24'h0000A5},
    // R1: 16-bit on 24-bit bus
    '{2'd0, 4'hF, 2'd3, 1'b0, 1'b0, 3'd2, 32'h0123FEDC, 24'h00FEDC, 24'h000123, 24'h0, 24'h0},
    // R3: 24-bit full, top byte ignored
    '{2'd3, 4'h7, 2'd3, 1'b0, 1'b0, 3'd1, 32'hA5C31E7F, 24'hC31E7F, 24'h0, 24'h0, 24'h0},
    // R4: narrowed on 18-bit bus
    '{2'd3, 4'h7, 2'd2, 1'b1, 1'b0, 3'd1, 32'hA5C31E7F, 24'h0037BF, 24'h0, 24'h0, 24'h0},
    // R4: narrowed on 16-bit bus
    '{2'd3, 4'h7, 2'd1, 1'b1, 1'b0, 3'd1, 32'h12FFEEDD, 24'h03FB9D, 24'h0, 24'h0, 24'h0},
    // R4: narrowed on 24-bit bus
    '{2'd3, 4'h7, 2'd3, 1'b1, 1'b0, 3'd1, 32'h12FFEEDD, 24'h03FB9D, 24'h0, 24'h0, 24'h0},
    // R5: narrowing flag has no effect in 16-bit mode
    '{2'd0, 4'hF, 2'd1, 1'b1, 1'b0, 3'd2, 32'hA5C31E7F, 24'h001E7F, 24'h00A5C3, 24'h0, 24'h0},
    // R6: word length code 1
    '{2'd1, 4'hF, 2'd1, 1'b0, 1'b1, 3'd0, 32'h11111111, 24'h0, 24'h0, 24'h0, 24'h0},
    // R6: 24-bit on 8-bit bus
    '{2'd3, 4'h7, 2'd0, 1'b1, 1'b1, 3'd0, 32'h22222222, 24'h0, 24'h0, 24'h0, 24'h0},
    // R6: mask mismatch in 16-bit mode
    '{2'd0, 4'h7, 2'd1, 1'b0, 1'b1, 3'd0, 32'h33333333, 24'h0, 24'h0, 24'h0, 24'h0},
    // R6: 24-bit on 18-bit bus without narrowing
    '{2'd3, 4'h7, 2'd2, 1'b0, 1'b1, 3'd0, 32'h44444444, 24'h0, 24'h0, 24'h0, 24'h0}
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] beat_of(input vec_t v, input int k);
    case (k)
      0: return v.b0;
      1: return v.b1;
      2: return v.b2;
      default: return v.b3;
    endcase
  endfunction

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R9 in_ready after reset", 32'(in_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      cfg_word_len  = VECS[i].wl;
      cfg_byte_mask = VECS[i].mask;
      cfg_bus_width = VECS[i].bus;
      cfg_narrow    = VECS[i].nar;
      out_ready     = 1'b1;
      @(negedge clk);
      chk($sformatf("R6 cfg_error row %0d", i), 32'(cfg_error), 32'(VECS[i].err));
      in_valid = 1'b1;
      in_data  = VECS[i].data;
      if (VECS[i].err) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk($sformatf("R6 in_ready row %0d", i), 32'(in_ready), 32'd0);
          chk($sformatf("R6 out_valid row %0d", i), 32'(out_valid), 32'd0);
        end
        in_valid = 1'b0;
      end else begin
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < int'(VECS[i].nb); k++) begin
          chk($sformatf("R1-5 row %0d beat %0d valid", i, k), 32'(out_valid), 32'd1);
          chk($sformatf("R1-5 row %0d beat %0d data", i, k), 32'(out_data), 32'(beat_of(VECS[i], k)));
          @(negedge clk);
        end
        chk($sformatf("R1-5 row %0d drained", i), 32'(out_valid), 32'd0);
      end
    end

    // R7 and R8: back-pressure, then a seamless second word
    cfg_word_len = 2'd0; cfg_byte_mask = 4'hF; cfg_bus_width = 2'd1; cfg_narrow = 1'b0;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'hBEEF1234;
    @(negedge clk);
    in_data = 32'h5678CAFE;
    chk("R7 in_ready while held", 32'(in_ready), 32'd0);
    chk("R7 beat held", 32'(out_data), 32'h001234);
    @(negedge clk);
    chk("R7 beat stable", 32'(out_data), 32'h001234);
    chk("R7 valid stable", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R7 second beat", 32'(out_data), 32'h00BEEF);
    chk("R8 in_ready on last beat", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 no bubble valid", 32'(out_valid), 32'd1);
    chk("R8 next word first beat", 32'(out_data), 32'h00CAFE);
    @(negedge clk);
    chk("R8 next word second beat", 32'(out_data), 32'h005678);
    @(negedge clk);
    chk("R8 drained", 32'(out_valid), 32'd0);

    // R9: reset while a word is held empties the register
    in_valid = 1'b1; in_data = 32'h0F0F0F0F; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset clears held word", 32'(out_valid), 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule